// File: doc/BRIEF.md
# Text Overlay Scroll Offset Unit

This unit sits between the CPU and a 4096-cell character overlay memory. Each cell is a 32-bit word. A 16-bit control register holds a 12-bit roll offset in its low bits. The same register holds three flags: bit 13 selects the bitplane bank, bit 14 enables cursor blinking and bit 15 enables character blinking. Bit 12 is stored and read back but has no effect.

The CPU supplies a logical cell number. The unit returns the physical cell by adding the roll offset modulo 4096. Logical cell 0 is therefore always the top-left screen position, whatever the roll value is. Adding 85 to the offset scrolls the text up one line. Subtracting 85 scrolls it down one line. Adding 1 moves every character one cell to the left.

A display scanner walks the 85 x 48 visible cells in raster order, one cell for each `scan_step` pulse. It starts each frame at the roll offset, so 16 of the 4096 cells are never shown. A frame counter flips a blink phase every 16 completed frames. That phase gates the cursor and the character-blink attributes of the cell being displayed.

Top module: `ovl_roll_unit`

## Requirements
- R1: After reset, `ctrl_value` is 0, `img_sel` is 0, `scan_addr`, `scan_col` and `scan_row` are 0, and `blink_phase` is 0.
- R2: A cycle with `reg_wr` high loads `reg_wdata` into the control register. The value is on `ctrl_value` from the next cycle. `img_sel` equals bit 13 of the control register.
- R3: `cpu_phys` equals (`cpu_cell` + `ctrl_value[11:0]`) mod 4096, combinationally, so it wraps past cell 4095.
- R4: Each `scan_step` cycle that is not the last cell of a frame advances `scan_addr` by 1 mod 4096. It also advances `scan_col` by 1, or sets it to 0 and advances `scan_row` by 1 after column 84. Without `scan_step`, all three scan outputs hold.
- R5: The step that consumes the last cell sets `scan_addr` to the roll offset held in that cycle. A roll written in the middle of a frame does not change the addresses of the current frame.
- R6: `scan_last` is high exactly while the scanner is at row 47, column 84 (cell 4079). A step in that state returns `scan_col` and `scan_row` to 0.
- R7: `blink_phase` toggles one cycle after the step that completes every 16th frame, and changes at no other time.
- R8: When bit 15 is set, `cell_blink` is high and `blink_phase` is 1, `pix_fg` shows `cell_bg` instead of `cell_fg` (unless a cursor is shown). Otherwise `pix_fg` shows `cell_fg`.
- R9: `cursor_vis` is `cell_cursor` AND (NOT bit 14 OR NOT `blink_phase`). While `cursor_vis` is high, `pix_fg` is all ones (white), overriding the cell colours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control register write value |
| ctrl_value | output | 16 | Current control register |
| img_sel | output | 1 | Bitplane bank select (bit 13) |
| cpu_cell | input | 12 | CPU logical cell number |
| cpu_phys | output | 12 | Physical cell for the CPU access |
| scan_step | input | 1 | Advance display scanner by one cell |
| scan_addr | output | 12 | Physical cell the scanner is fetching |
| scan_col | output | 7 | Current text column, 0..84 |
| scan_row | output | 6 | Current text row, 0..47 |
| scan_last | output | 1 | Scanner is at the final visible cell |
| cell_fg | input | 4 | Foreground colour of the fetched cell |
| cell_bg | input | 4 | Background colour of the fetched cell |
| cell_cursor | input | 1 | Cursor attribute of the fetched cell |
| cell_blink | input | 1 | Blink attribute of the fetched cell |
| blink_phase | output | 1 | Current blink half-period (1 = off half) |
| pix_fg | output | 4 | Foreground colour to display |
| cursor_vis | output | 1 | Cursor shown in this cell |

## Verification
A corrupted scanner counter shows up at once as a wrong `scan_addr`, column or row on the next step. A corrupted row counter can also surface only at the end of a frame, as a `scan_last` in the wrong place or a missing return to the roll offset. Bad roll capture logic is visible only on the step after cell 4079, so mid-frame writes are placed where they would alter that frame if captured early. A wrong blink frame count shows only after 15 to 16 frames, as a phase flip that comes too early or too late. The bench therefore observes the phase at both of those frame counts.

// File: rtl/ovl_roll_pkg.sv
package ovl_roll_pkg;
    localparam int CTRL_W   = 16;
    localparam int ROLL_W   = 12;
    localparam int IMG_BIT  = 13;
    localparam int CUR_BIT  = 14;
    localparam int CHR_BIT  = 15;
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl
);
    typedef struct packed {
        logic [CTRL_W-1:0] val;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.val = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.val;
endmodule

// File: rtl/ovl_scan_seq.sv
module ovl_scan_seq #(
    parameter int ADDR_W = 12,
    parameter int COLS   = 85,
    parameter int ROWS   = 48,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [ADDR_W-1:0] roll,
    output logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic              last,
    output logic              frame_done
);
    localparam logic [COL_W-1:0] COL_END = COL_W'(COLS - 1);
    localparam logic [ROW_W-1:0] ROW_END = ROW_W'(ROWS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
    } st_t;

    st_t st_d, st_q;
    logic col_end, row_end;

    always_comb begin
        col_end = (st_q.col == COL_END);
        row_end = (st_q.row == ROW_END);
        st_d    = st_q;
        if (step) begin
            if (col_end && row_end) begin
                // new frame begins at the roll offset held right now
                st_d.addr = roll;
                st_d.col  = '0;
                st_d.row  = '0;
            end else begin
                st_d.addr = st_q.addr + ADDR_W'(1);
                if (col_end) begin
                    st_d.col = '0;
                    st_d.row = st_q.row + ROW_W'(1);
                end else begin
                    st_d.col = st_q.col + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr       = st_q.addr;
    assign col        = st_q.col;
    assign row        = st_q.row;
    assign last       = col_end && row_end;
    assign frame_done = step && col_end && row_end;
endmodule

// File: rtl/ovl_blink_gen.sv
module ovl_blink_gen #(
    parameter int BLINK_FRAMES = 16,
    parameter int CW           = 4,
    localparam int CNT_W       = (BLINK_FRAMES > 1) ? $clog2(BLINK_FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic          chr_en,
    input  logic          cur_en,
    input  logic [CW-1:0] cell_fg,
    input  logic [CW-1:0] cell_bg,
    input  logic          cell_cursor,
    input  logic          cell_blink,
    output logic          phase,
    output logic [CW-1:0] fg_out,
    output logic          cursor_on
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BLINK_FRAMES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_done) begin
            if (st_q.cnt == CNT_END) begin
                st_d.cnt   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cursor_on = cell_cursor && (!cur_en || !st_q.phase);
        if (cursor_on)
            fg_out = '1;
        else if (chr_en && cell_blink && st_q.phase)
            fg_out = cell_bg;
        else
            fg_out = cell_fg;
    end

    assign phase = st_q.phase;
endmodule

// File: rtl/ovl_roll_unit.sv
module ovl_roll_unit
    import ovl_roll_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int COLS         = 85,
    parameter int ROWS         = 48,
    parameter int BLINK_FRAMES = 16,
    parameter int CW           = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [15:0]              reg_wdata,
    output logic [15:0]              ctrl_value,
    output logic                     img_sel,
    input  logic [ADDR_W-1:0]        cpu_cell,
    output logic [ADDR_W-1:0]        cpu_phys,
    input  logic                     scan_step,
    output logic [ADDR_W-1:0]        scan_addr,
    output logic [$clog2(COLS)-1:0]  scan_col,
    output logic [$clog2(ROWS)-1:0]  scan_row,
    output logic                     scan_last,
    input  logic [CW-1:0]            cell_fg,
    input  logic [CW-1:0]            cell_bg,
    input  logic                     cell_cursor,
    input  logic                     cell_blink,
    output logic                     blink_phase,
    output logic [CW-1:0]            pix_fg,
    output logic                     cursor_vis
);
    logic [ADDR_W-1:0] roll;
    logic              frame_done;

    ovl_ctrl_reg #(.CTRL_W(CTRL_W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .ctrl  (ctrl_value)
    );

    assign roll     = ctrl_value[ADDR_W-1:0];
    assign img_sel  = ctrl_value[IMG_BIT];
    // modulo 2^ADDR_W wrap comes from the truncating add
    assign cpu_phys = cpu_cell + roll;

    ovl_scan_seq #(.ADDR_W(ADDR_W), .COLS(COLS), .ROWS(ROWS)) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (scan_step),
        .roll       (roll),
        .addr       (scan_addr),
        .col        (scan_col),
        .row        (scan_row),
        .last       (scan_last),
        .frame_done (frame_done)
    );

    ovl_blink_gen #(.BLINK_FRAMES(BLINK_FRAMES), .CW(CW)) blink_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .chr_en      (ctrl_value[CHR_BIT]),
        .cur_en      (ctrl_value[CUR_BIT]),
        .cell_fg     (cell_fg),
        .cell_bg     (cell_bg),
        .cell_cursor (cell_cursor),
        .cell_blink  (cell_blink),
        .phase       (blink_phase),
        .fg_out      (pix_fg),
        .cursor_on   (cursor_vis)
    );
endmodule

// File: rtl/ovl_roll_unit_chk.sv
module ovl_roll_unit_chk #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 7,
    parameter int ROW_W  = 6,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       ctrl_value,
    input logic              scan_step,
    input logic [ADDR_W-1:0] scan_addr,
    input logic [COL_W-1:0]  scan_col,
    input logic [ROW_W-1:0]  scan_row,
    input logic              scan_last,
    input logic              blink_phase,
    input logic [CW-1:0]     pix_fg,
    input logic              cursor_vis
);
    assert_wr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> ctrl_value == $past(reg_wdata));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_step && !scan_last) |=> scan_addr == $past(scan_addr) + ADDR_W'(1));

    assert_scan_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_step |=> ($stable(scan_addr) && $stable(scan_col) && $stable(scan_row)));

    assert_frame_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_step && scan_last) |=> scan_addr == $past(ctrl_value[ADDR_W-1:0]));

    assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_step && scan_last) |=> (scan_col == '0 && scan_row == '0));

    assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(scan_step && scan_last) |=> $stable(blink_phase));

    assert_cursor_white_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cursor_vis |-> pix_fg == '1);
endmodule

bind ovl_roll_unit ovl_roll_unit_chk #(
    .ADDR_W (ADDR_W),
    .COL_W  ($clog2(COLS)),
    .ROW_W  ($clog2(ROWS)),
    .CW     (CW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .ctrl_value  (ctrl_value),
    .scan_step   (scan_step),
    .scan_addr   (scan_addr),
    .scan_col    (scan_col),
    .scan_row    (scan_row),
    .scan_last   (scan_last),
    .blink_phase (blink_phase),
    .pix_fg      (pix_fg),
    .cursor_vis  (cursor_vis)
);

// File: tb/ovl_roll_unit_tb_top.sv
module ovl_roll_unit_tb_top;
    localparam int CELLS = 85 * 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] ctrl_value;
    logic        img_sel;
    logic [11:0] cpu_cell = '0;
    logic [11:0] cpu_phys;
    logic        scan_step = 1'b0;
    logic [11:0] scan_addr;
    logic [6:0]  scan_col;
    logic [5:0]  scan_row;
    logic        scan_last;
    logic [3:0]  cell_fg = '0;
    logic [3:0]  cell_bg = '0;
    logic        cell_cursor = 1'b0;
    logic        cell_blink = 1'b0;
    logic        blink_phase;
    logic [3:0]  pix_fg;
    logic        cursor_vis;

    always #2 clk = ~clk;

    ovl_roll_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .ctrl_value(ctrl_value), .img_sel(img_sel), .cpu_cell(cpu_cell),
        .cpu_phys(cpu_phys), .scan_step(scan_step), .scan_addr(scan_addr),
        .scan_col(scan_col), .scan_row(scan_row), .scan_last(scan_last),
        .cell_fg(cell_fg), .cell_bg(cell_bg), .cell_cursor(cell_cursor),
        .cell_blink(cell_blink), .blink_phase(blink_phase), .pix_fg(pix_fg),
        .cursor_vis(cursor_vis)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int addr;
        int col;
        int row;
        int last;
    } exp_t;
    exp_t sb_q[$];

    int m_addr = 0, m_col = 0, m_row = 0, m_k = 0, m_roll = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: predicts the scanner state seen in this cycle, then steps
    task automatic run_steps(int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            e.addr = m_addr; e.col = m_col; e.row = m_row;
            e.last = (m_k == CELLS - 1) ? 1 : 0;
            sb_q.push_back(e);
            scan_step = 1'b1;
            if (m_k == CELLS - 1) begin
                m_k = 0; m_col = 0; m_row = 0; m_addr = m_roll;
            end else begin
                m_k++;
                m_addr = (m_addr + 1) % 4096;
                if (m_col == 84) begin m_col = 0; m_row++; end
                else m_col++;
            end
        end
        @(negedge clk);
        scan_step = 1'b0;
        #1;
    endtask

    // monitor: compares each stepped cycle against the scoreboard (R4, R5, R6)
    always @(negedge clk) begin
        #1;
        if (scan_step && rst_n) begin
            if (sb_q.size() == 0) begin
                chk("R4 scoreboard underflow", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4/R5 scan_addr", int'(scan_addr), e.addr);
                chk("R4 scan_col", int'(scan_col), e.col);
                chk("R4 scan_row", int'(scan_row), e.row);
                chk("R6 scan_last", int'(scan_last), e.last);
            end
        end
    end

    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        m_roll = int'(v[11:0]);
        #1;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ctrl_value", int'(ctrl_value), 0);
        chk("R1 img_sel", int'(img_sel), 0);
        chk("R1 scan_addr", int'(scan_addr), 0);
        chk("R1 scan_col", int'(scan_col), 0);
        chk("R1 scan_row", int'(scan_row), 0);
        chk("R1 blink_phase", int'(blink_phase), 0);

        // R2 load, image select on bit 13; roll = 100
        wr_ctrl(16'h2064);
        chk("R2 ctrl_value", int'(ctrl_value), 16'h2064);
        chk("R2 img_sel", int'(img_sel), 1);
        // R3 logical to physical translation with wrap
        cpu_cell = 12'd0;    #1; chk("R3 cell 0", int'(cpu_phys), 100);
        cpu_cell = 12'd4000; #1; chk("R3 cell 4000 wrap", int'(cpu_phys), 4);
        cpu_cell = 12'd85;   #1; chk("R3 cell 85", int'(cpu_phys), 185);

        // R5 frame 0 started at 0 before the roll write; frame 1 starts at 100
        run_steps(CELLS);
        chk("R5 frame start addr", int'(scan_addr), 100);
        // roll changed to 185 in mid frame (scroll up one line), bits 14/15 set
        run_steps(1000);
        wr_ctrl(16'hC0B9);
        chk("R2 img_sel cleared", int'(img_sel), 0);
        run_steps(CELLS - 1000);
        chk("R5 next frame uses new roll", int'(scan_addr), 185);

        // R8 / R9 with phase 0
        cell_fg = 4'd3; cell_bg = 4'd9; cell_blink = 1'b1; cell_cursor = 1'b0; #1;
        chk("R8 phase0 shows fg", int'(pix_fg), 3);
        cell_cursor = 1'b1; #1;
        chk("R9 cursor visible phase0", int'(cursor_vis), 1);
        chk("R9 cursor white", int'(pix_fg), 15);
        cell_cursor = 1'b0;

        // R7 phase after 15 and 16 frames
        run_steps(13 * CELLS);
        chk("R7 phase after 15 frames", int'(blink_phase), 0);
        run_steps(CELLS);
        chk("R7 phase after 16 frames", int'(blink_phase), 1);

        // R8 blinking character in off half
        #1; chk("R8 phase1 shows bg", int'(pix_fg), 9);
        cell_blink = 1'b0; #1;
        chk("R8 non-blink cell keeps fg", int'(pix_fg), 3);
        cell_blink = 1'b1;
        wr_ctrl(16'h40B9);
        chk("R8 char blink disabled", int'(pix_fg), 3);
        // R9 cursor blinking hidden in off half, steady when disabled
        cell_cursor = 1'b1; #1;
        chk("R9 cursor hidden phase1", int'(cursor_vis), 0);
        chk("R9 hidden cursor colour", int'(pix_fg), 3);
        wr_ctrl(16'h00B9);
        chk("R9 cursor steady", int'(cursor_vis), 1);
        chk("R9 steady cursor white", int'(pix_fg), 15);
        cell_cursor = 1'b0;

        // R3 wrap with maximum roll
        wr_ctrl(16'h0FFF);
        cpu_cell = 12'd1;    #1; chk("R3 roll 4095 cell 1", int'(cpu_phys), 0);
        cpu_cell = 12'd4095; #1; chk("R3 roll 4095 cell 4095", int'(cpu_phys), 4094);

        // R4 hold without step
        repeat (3) @(negedge clk);
        #1;
        chk("R4 hold addr", int'(scan_addr), m_addr);
        chk("R4 scoreboard drained", sb_q.size(), 0);
        summary();
    end
endmodule